// File: doc/BRIEF.md
# Six-Lane Serial ADC Capture Engine

This block is a receive-only serial master that reads three dual-channel, 12-bit converters at the same time. All three converters share one active-low chip select and one serial clock. Each converter returns two serial data lines, one carrying a motor phase voltage and one carrying that phase current, so six lines are captured in parallel in every frame. No line goes back to the converters, because they need no setup traffic.

The serial clock comes from the system clock: each level is held for `HALF_CYC` system cycles. A frame is fourteen serial clock periods long. The converters shift data out on falling edges, and the block samples on rising edges. The first two bits of each frame are always zero and are thrown away. The remaining twelve bits, most significant first, become one sample per lane. Each sample is then offered on its own AXI4-Stream master output as a single beat.

Frames run back to back while a start input is high. That input is the motor-enable control from another clock domain, so it passes through a two-flop synchroniser before use. A frame that is under way when start falls is always finished.

Top module: `adc_frame_capture`

## Requirements
- R1: While `rst_n` is low (synchronous reset), and at the first clock after it is released, `adc_cs_n` and `adc_sclk` are 1 and all bits of `m_tvalid` and `m_overrun` are 0. A reset also clears any overrun flag that was set before it.
- R2: While the synchronised start is low and the block is idle, `adc_cs_n` stays high. `start_async` passes through two flops, so `adc_cs_n` is still high two clock edges after `start_async` rises. It falls on the third edge once the idle gap of R7 has been met. `adc_sclk` is 1 whenever `adc_cs_n` is 1.
- R3: During each low interval of `adc_cs_n` there are exactly 14 falling edges of `adc_sclk`. Every low level and every high level of `adc_sclk` lasts exactly `HALF_CYC` clock cycles.
- R4: Every data line is sampled as `adc_sclk` rises. The first falling edge of a frame presents bit 13 of the converter word, and the data changes on each falling edge after that.
- R5: The first two bits of a frame (bits 13 and 12) are dropped, whatever their value. Bits 11..0, arriving most significant first, form the sample, which is zero-extended into the 16-bit stream word so that bits 15..12 are 0.
- R6: Lane i is captured from `adc_sdata[i]` and presented on `m_tdata[16*i+15:16*i]`, `m_tvalid[i]` and `m_tready[i]`. Lanes 0 to 5 are phase A voltage, phase A current, phase B voltage, phase B current, phase C voltage and phase C current.
- R7: Between two frames, `adc_cs_n` stays high for at least `2*HALF_CYC` clock cycles, which is one full serial clock period.
- R8: `m_tvalid` rises on the same clock edge on which `adc_cs_n` returns high at the end of a frame. While `m_tready` is low, `m_tvalid` and `m_tdata` hold. One cycle with `m_tready` high clears `m_tvalid`, unless a new frame completes in that same cycle.
- R9: When a frame completes while a lane still holds a sample that was not accepted, the new sample replaces the old one, `m_tvalid` stays 1, and that lane's `m_overrun` bit is set. The bit stays set until reset.
- R10: When start is deasserted in the middle of a frame, that frame still completes and delivers its samples, and no further frame begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_async | input | 1 | Conversion enable from another clock domain |
| adc_cs_n | output | 1 | Shared active-low chip select |
| adc_sclk | output | 1 | Shared serial clock, idles high |
| adc_sdata | input | 6 | Serial data lines, one per lane |
| m_tdata | output | 96 | Stream data, 16 bits per lane, lane 0 in the low bits |
| m_tvalid | output | 6 | Stream valid, one per lane |
| m_tready | input | 6 | Stream ready, one per lane |
| m_overrun | output | 6 | Sticky flag per lane: a sample was replaced before it was accepted |

## Verification
The capture path is driven with bit patterns that separate the possible faults:

- **All zeros and all ones** show that no bit is stuck.
- **Alternating patterns** expose a shift by one position, or sampling on the wrong edge.
- **Single-bit words at the top and the bottom** pin down the bit order.
- **Ones in the two leading bit slots** show that those bits are really dropped and not merged into the sample.

Each lane receives a different word in every frame, so crossed lanes show up as a data mismatch. Directed runs then hold start low to check gating, drop start in the middle of a frame, and hold ready low across two frames to check hold and overrun. A timing monitor measures the serial clock level widths, the edges per frame and the idle gap.

// File: rtl/adcc_pkg.sv
// Shared types and lane assignments for the six-lane serial ADC capture engine.
package adcc_pkg;

    // Frame sequencer states: idle with chip select high, then alternating clock levels.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_LOW  = 2'd1,
        SEQ_HIGH = 2'd2
    } seq_state_t;

    // Lane order on the data inputs and stream outputs.
    localparam int LANE_VOLT_A = 0;
    localparam int LANE_CURR_A = 1;
    localparam int LANE_VOLT_B = 2;
    localparam int LANE_CURR_B = 3;
    localparam int LANE_VOLT_C = 4;
    localparam int LANE_CURR_C = 5;

endpackage

// File: rtl/adcc_sync2.sv
// Two-flop synchroniser for a single level signal from another clock domain.
// Assumes the source level is held for several destination clock cycles.
module adcc_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic meta_q;

    // Capture the asynchronous level through two back-to-back flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            q_sync <= 1'b0;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end
endmodule

// File: rtl/adcc_frame_seq.sv
// Frame sequencer: divides the system clock into the serial clock, drives the
// shared chip select and issues a shift strobe for every retained bit plus a
// strobe when a frame ends. Assumes HALF_CYC >= 1 and FRAME_BITS > SAMPLE_W.
module adcc_frame_seq
    import adcc_pkg::*;
#(
    parameter int HALF_CYC   = 2,
    parameter int FRAME_BITS = 14,
    parameter int SAMPLE_W   = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_s,
    output logic cs_n,
    output logic sclk,
    output logic shift_en,
    output logic frame_done
);
    localparam int HC_W  = $clog2(HALF_CYC + 1);
    localparam int GAP   = 2 * HALF_CYC;
    localparam int GAP_W = $clog2(GAP + 1);
    localparam int BIT_W = $clog2(FRAME_BITS);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);
    localparam logic [BIT_W-1:0] KEEP_LIM = BIT_W'(SAMPLE_W);

    seq_state_t       state_q;
    logic [HC_W-1:0]  hcnt_q;
    logic [GAP_W-1:0] gcnt_q;
    logic [BIT_W-1:0] bit_q;
    logic             half_done;
    logic             gap_done;

    assign half_done = (hcnt_q == HC_W'(HALF_CYC - 1));
    assign gap_done  = (gcnt_q == GAP_W'(GAP - 1));

    // Sequence idle gap, clock levels and the bit countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            hcnt_q  <= '0;
            gcnt_q  <= '0;
            bit_q   <= LAST_BIT;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    hcnt_q <= '0;
                    if (gap_done && start_s) begin
                        state_q <= SEQ_LOW;
                        gcnt_q  <= '0;
                        bit_q   <= LAST_BIT;
                    end else if (!gap_done) begin
                        gcnt_q <= gcnt_q + 1'b1;
                    end
                end
                SEQ_LOW: begin
                    if (half_done) begin
                        hcnt_q  <= '0;
                        state_q <= SEQ_HIGH;
                    end else begin
                        hcnt_q <= hcnt_q + 1'b1;
                    end
                end
                SEQ_HIGH: begin
                    if (half_done) begin
                        hcnt_q <= '0;
                        if (bit_q == '0) begin
                            state_q <= SEQ_IDLE;
                        end else begin
                            bit_q   <= bit_q - 1'b1;
                            state_q <= SEQ_LOW;
                        end
                    end else begin
                        hcnt_q <= hcnt_q + 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Decode pin levels and strobes from the state registers.
    always_comb begin
        cs_n       = (state_q == SEQ_IDLE);
        sclk       = (state_q != SEQ_LOW);
        shift_en   = (state_q == SEQ_LOW) && half_done && (bit_q < KEEP_LIM);
        frame_done = (state_q == SEQ_HIGH) && half_done && (bit_q == '0);
    end

    // ---- checker state: observed pin history ----
    logic             chk_cs_q;
    logic             chk_sclk_q;
    logic [7:0]       chk_falls;
    logic [GAP_W:0]   chk_gap;

    // Track falling serial clock edges per frame and the chip-select-high run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_cs_q   <= 1'b1;
            chk_sclk_q <= 1'b1;
            chk_falls  <= '0;
            chk_gap    <= '0;
        end else begin
            chk_cs_q   <= cs_n;
            chk_sclk_q <= sclk;
            if (cs_n && chk_cs_q)
                chk_falls <= '0;
            else if (chk_sclk_q && !sclk && chk_falls != 8'hFF)
                chk_falls <= chk_falls + 1'b1;
            if (!cs_n)
                chk_gap <= '0;
            else if (chk_gap != {(GAP_W+1){1'b1}})
                chk_gap <= chk_gap + 1'b1;
        end
    end

    // R2
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> sclk);
    // R2
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) (!start_s && cs_n) |=> cs_n);
    // R3
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> (chk_falls == 8'(FRAME_BITS)));
    // R7
    idle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (chk_gap >= (GAP_W+1)'(GAP)));
endmodule

// File: rtl/adcc_lane.sv
// One capture lane: shifts in retained bits MSB first, then holds the finished
// sample on an AXI4-Stream master output with a sticky overrun flag.
// Assumes shift_en and frame_done come from the shared frame sequencer.
module adcc_lane #(
    parameter int SAMPLE_W = 12,
    parameter int TDATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sdata,
    input  logic               shift_en,
    input  logic               frame_done,
    input  logic               tready,
    output logic [TDATA_W-1:0] tdata,
    output logic               tvalid,
    output logic               overrun
);
    localparam int PAD_W = TDATA_W - SAMPLE_W;

    logic [SAMPLE_W-1:0] shreg_q;

    // Shift the serial bit in at each retained rising clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shreg_q <= '0;
        else if (shift_en)
            shreg_q <= {shreg_q[SAMPLE_W-2:0], sdata};
    end

    // Present the finished sample, honour the handshake, flag overwrites.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tdata   <= '0;
            tvalid  <= 1'b0;
            overrun <= 1'b0;
        end else if (frame_done) begin
            tdata  <= {{PAD_W{1'b0}}, shreg_q};
            tvalid <= 1'b1;
            if (tvalid && !tready)
                overrun <= 1'b1;
        end else if (tvalid && tready) begin
            tvalid <= 1'b0;
        end
    end

    // R8
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tvalid && !tready) |=> tvalid);
    // R8
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tvalid && !tready && !frame_done) |=> $stable(tdata));
    // R9
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
    // R5
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tvalid |-> (tdata[TDATA_W-1:SAMPLE_W] == '0));
endmodule

// File: rtl/adc_frame_capture.sv
// Top of the six-lane serial ADC capture engine. Synchronises the start input,
// runs the shared frame sequencer and one capture lane per data line.
// Assumes the converters change data on falling serial clock edges.
module adc_frame_capture #(
    parameter int LANES      = 6,
    parameter int HALF_CYC   = 2,
    parameter int FRAME_BITS = 14,
    parameter int SAMPLE_W   = 12,
    parameter int TDATA_W    = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_async,
    output logic                     adc_cs_n,
    output logic                     adc_sclk,
    input  logic [LANES-1:0]         adc_sdata,
    output logic [LANES*TDATA_W-1:0] m_tdata,
    output logic [LANES-1:0]         m_tvalid,
    input  logic [LANES-1:0]         m_tready,
    output logic [LANES-1:0]         m_overrun
);
    logic start_s;
    logic shift_en;
    logic frame_done;

    adcc_sync2 u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (start_async),
        .q_sync  (start_s)
    );

    adcc_frame_seq #(
        .HALF_CYC   (HALF_CYC),
        .FRAME_BITS (FRAME_BITS),
        .SAMPLE_W   (SAMPLE_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_s    (start_s),
        .cs_n       (adc_cs_n),
        .sclk       (adc_sclk),
        .shift_en   (shift_en),
        .frame_done (frame_done)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        adcc_lane #(
            .SAMPLE_W (SAMPLE_W),
            .TDATA_W  (TDATA_W)
        ) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .sdata      (adc_sdata[i]),
            .shift_en   (shift_en),
            .frame_done (frame_done),
            .tready     (m_tready[i]),
            .tdata      (m_tdata[i*TDATA_W +: TDATA_W]),
            .tvalid     (m_tvalid[i]),
            .overrun    (m_overrun[i])
        );
    end

    // R6
    lanes_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~m_tvalid) || (m_tvalid == '1) || (m_tvalid == '0) || (m_tready != '1));
endmodule

// File: tb/sim_adc_frame_capture.sv
// Self-checking bench: converter models on the six data lines, a vector table
// walked by one loop, then directed tests for gating, mid-frame stop and overrun.
module sim_adc_frame_capture;
    localparam int LN   = 6;
    localparam int HALF = 2;
    localparam int SW   = 12;
    localparam int TW   = 16;

    // [13:12] leading bits driven by the converter, [11:0] base sample
    localparam logic [13:0] VEC [0:5] = '{
        14'h0000, 14'h0FFF, 14'h0A5A, 14'h35A5, 14'h1800, 14'h2001
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic cs_n, sclk;
    logic [LN-1:0] sdata = '0;
    logic [LN-1:0] tvalid, ovr;
    logic [LN-1:0] tready = '1;
    logic [LN*TW-1:0] tdata;

    always #4 clk = ~clk;

    adc_frame_capture #(.HALF_CYC(HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .start_async(start),
        .adc_cs_n(cs_n), .adc_sclk(sclk), .adc_sdata(sdata),
        .m_tdata(tdata), .m_tvalid(tvalid), .m_tready(tready), .m_overrun(ovr)
    );

    int checks = 0;
    int fails  = 0;

    // converter models: word presented MSB first, one bit per falling edge
    logic [13:0] words [LN];
    int bidx = 13;
    always @(posedge cs_n) bidx = 13;
    always @(negedge sclk) begin
        for (int l = 0; l < LN; l++) sdata[l] <= words[l][(bidx >= 0) ? bidx : 0];
        bidx <= bidx - 1;
    end

    // timing monitor, sampled away from the active edge
    int falls = 0, last_falls = 0, gap = 0, min_gap = 1000;
    int low_run = 0, min_low = 1000, max_low = 0;
    logic sclk_p = 1'b1, cs_p = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (sclk_p && !sclk) falls++;
            if (!cs_p && cs_n) begin last_falls = falls; falls = 0; end
            if (!sclk) low_run++;
            else if (low_run > 0) begin
                if (low_run < min_low) min_low = low_run;
                if (low_run > max_low) max_low = low_run;
                low_run = 0;
            end
            if (cs_n) gap++;
            else if (gap > 0) begin
                if (gap < min_gap) min_gap = gap;
                gap = 0;
            end
        end
        sclk_p = sclk;
        cs_p   = cs_n;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] samp(input int v, input int l);
        return VEC[v][11:0] ^ 12'(l * 12'h249);
    endfunction

    task automatic set_words(input int v);
        for (int l = 0; l < LN; l++) words[l] = {VEC[v][13:12], samp(v, l)};
    endtask

    task automatic wait_valid(output bit got);
        got = 1'b0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (tvalid == '1) begin got = 1'b1; break; end
        end
    endtask

    task automatic wait_cs(input logic lvl);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (cs_n == lvl) break;
        end
    endtask

    task automatic chk_lanes(input int v, input string req);
        for (int l = 0; l < LN; l++)
            chk(tdata[l*TW +: TW] == {4'b0, samp(v, l)}, req, tdata[l*TW +: TW], {4'b0, samp(v, l)});
    endtask

    // watchdog: a hung run is a failed check
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        bit got;
        int lows;
        set_words(0);
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(cs_n == 1'b1, "R1 cs_n in reset", cs_n, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n == 1'b1, "R1 cs_n", cs_n, 1);
        chk(sclk == 1'b1, "R1 sclk", sclk, 1);
        chk(tvalid == '0, "R1 tvalid", tvalid, 0);
        chk(ovr == '0, "R1 overrun", ovr, 0);

        // R2: start low keeps the bus idle
        lows = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (!cs_n || !sclk) lows++;
        end
        chk(lows == 0, "R2 gated idle", lows, 0);

        // R2: two-flop synchroniser latency
        start = 1'b1;
        @(negedge clk);
        chk(cs_n == 1'b1, "R2 cs_n after 1 edge", cs_n, 1);
        @(negedge clk);
        chk(cs_n == 1'b1, "R2 cs_n after 2 edges", cs_n, 1);
        @(negedge clk);
        chk(cs_n == 1'b0, "R2 cs_n after 3 edges", cs_n, 0);

        // table walk: R4 R5 R6 R8 on back-to-back frames
        for (int v = 0; v < 6; v++) begin
            wait_valid(got);
            chk(got, "R8 tvalid at frame end", tvalid, 6'h3f);
            chk(cs_n == 1'b1, "R8 cs_n high with tvalid", cs_n, 1);
            chk_lanes(v, "R4 R5 R6 lane data");
            if (v < 5) set_words(v + 1);
            else start = 1'b0;
            @(negedge clk);
            chk(tvalid == '0, "R8 tvalid cleared by tready", tvalid, 0);
        end

        // R3 / R7: serial clock shape and idle gap
        chk(last_falls == 14, "R3 falls per frame", last_falls, 14);
        chk(min_low == HALF, "R3 min low width", min_low, HALF);
        chk(max_low == HALF, "R3 max low width", max_low, HALF);
        chk(min_gap >= 2 * HALF, "R7 idle gap", min_gap, 2 * HALF);

        // R10: stop in the middle of a frame
        repeat (10) @(negedge clk);
        set_words(2);
        start = 1'b1;
        wait_cs(1'b0);
        repeat (10) @(negedge clk);
        start = 1'b0;
        wait_valid(got);
        chk(got, "R10 frame completes", tvalid, 6'h3f);
        chk_lanes(2, "R10 data of finished frame");
        lows = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!cs_n) lows++;
        end
        chk(lows == 0, "R10 no further frame", lows, 0);

        // R8 / R9: backpressure across two frames
        tready = '0;
        set_words(3);
        start = 1'b1;
        wait_valid(got);
        chk(got, "R8 first frame valid", tvalid, 6'h3f);
        chk_lanes(3, "R8 first frame data");
        chk(ovr == '0, "R9 no overrun yet", ovr, 0);
        set_words(4);
        repeat (3) @(negedge clk);
        chk(tvalid == '1, "R8 valid held", tvalid, 6'h3f);
        chk_lanes(3, "R8 data held");
        wait_cs(1'b0);
        wait_cs(1'b1);
        start = 1'b0;
        chk(tvalid == '1, "R9 valid kept", tvalid, 6'h3f);
        chk_lanes(4, "R9 data replaced");
        chk(ovr == '1, "R9 overrun set", ovr, 6'h3f);
        tready = '1;
        @(negedge clk);
        chk(tvalid == '0, "R8 accepted", tvalid, 0);
        chk(ovr == '1, "R9 overrun sticky", ovr, 6'h3f);

        // R1: reset clears the sticky flag
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ovr == '0, "R1 overrun cleared", ovr, 0);
        chk(cs_n == 1'b1 && sclk == 1'b1, "R1 pins idle", {cs_n, sclk}, 2'b11);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule